// File: doc/BRIEF.md
# E1 Timeslot Timing and Channel Block Generator

This block tracks the position of the current bit inside a 2.048 Mbit/s E1 frame. A bit counter walks through the eight bits of a timeslot, and a slot counter walks through the 32 timeslots of a frame. A single parity flag separates the frames that carry the alignment word from the frames that do not. A frame sync pulse realigns all three counters at any time.

From that position the block produces three strobes for the serial logic around it:
- a channel clock, high during the last bit of every timeslot, used for serial-to-parallel conversion;
- a channel block output that a 32-bit host mask sets per timeslot, used to gate clocks for fractional-rate services. An optional G.802 rule forces it high in the first bit of timeslot 26.
- a link clock that pulses on the spare national bits of timeslot 0 in non-alignment frames that the host has selected.

Every output is registered and lines up with the position ports in the same cycle.

Top module: `e1_slot_timer`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it, all strobes are low and the position reads timeslot 0, bit 1 (bit_o=0), alignment frame (frame_odd_o=0).
- R2: bit_o counts 0..7 (bits 1..8, MSB first). After bit_o=7, slot_o advances by one and wraps from 31 to 0.
- R3: frame_odd_o toggles on each step from timeslot 31, bit 8 to timeslot 0, bit 1. frame_odd_o=1 marks a non-alignment frame.
- R4: After a clock edge that samples fsync_i high, the next state is timeslot 0, bit 1, alignment frame, whatever the previous state was.
- R5: chan_clk_o is high exactly in cycles where bit_o=7.
- R6: chan_blk_o equals blk_mask_i[n] for all eight bits of timeslot n, where mask bit n belongs to timeslot n.
- R7: When g802_en_i is set, chan_blk_o is high in bit 1 of timeslot 26 whatever the mask holds. In the other bits of that slot the mask alone decides.
- R8: link_clk_o is high in timeslot 0 of a non-alignment frame at bit k+4 (bit_o=k+3) when sa_sel_i[k] is set, with k=0 for Sa4 up to k=4 for Sa8.
- R9: link_clk_o stays low in alignment frames, outside timeslot 0 bits 4..8, and at any unselected Sa position.
- R10: Each strobe is the registered decode of the position that is valid in the same cycle, so a single pulse lasts exactly one bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one edge per E1 bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; reloads the position on the next edge |
| blk_mask_i | input | 32 | Channel block level per timeslot |
| g802_en_i | input | 1 | Enables the forced block in timeslot 26, bit 1 |
| sa_sel_i | input | 5 | Sa4..Sa8 link clock select, bit 0 = Sa4 |
| chan_clk_o | output | 1 | High during bit 8 of each timeslot |
| chan_blk_o | output | 1 | Channel block strobe |
| link_clk_o | output | 1 | Sa-bit demand clock |
| slot_o | output | 5 | Current timeslot |
| bit_o | output | 3 | Current bit within timeslot, 0 = bit 1 |
| frame_odd_o | output | 1 | 1 in non-alignment frames |

## Verification
A wrong bit or slot count shows up at once on slot_o and bit_o. It also shifts chan_clk_o and chan_blk_o within the same bit period, so the per-cycle compare catches it on the first bad cycle. A parity error is quieter: it only appears as link clock pulses in the wrong frame, at most one frame (256 cycles) later. The stimulus therefore uses several Sa selections and runs across many frame wraps. Frame syncs are placed mid-frame and in the last slot, so that a reload that misses the parity or the bit count also diverges within one cycle.

// File: rtl/e1_slot_pkg.sv
package e1_slot_pkg;
  localparam int unsigned BITS_PER_SLOT = 8;
  localparam int unsigned SLOTS_PER_FRAME = 32;
  localparam int unsigned BIT_W = $clog2(BITS_PER_SLOT);
  localparam int unsigned SLOT_W = $clog2(SLOTS_PER_FRAME);
  localparam int unsigned SA_FIRST = 3;   // zero-based bit index of Sa4
  localparam int unsigned SA_COUNT = 5;
  localparam int unsigned G802_SLOT = 26;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bit_idx;
    logic              odd;
  } e1_pos_t;
endpackage

// File: rtl/e1_pos_counter.sv
module e1_pos_counter
  import e1_slot_pkg::*;
#(
  parameter int unsigned BITS = BITS_PER_SLOT,
  parameter int unsigned SLOTS = SLOTS_PER_FRAME
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fsync_i,
  output e1_pos_t pos_q_o,
  output e1_pos_t pos_d_o
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  e1_pos_t pos_q, pos_d;
  logic    slot_end, frame_end;

  assign slot_end  = (pos_q.bit_idx == LAST_BIT);
  assign frame_end = slot_end && (pos_q.slot == LAST_SLOT);

  always_comb begin
    pos_d = pos_q;
    if (fsync_i) begin
      pos_d = '0;
    end else begin
      pos_d.bit_idx = slot_end ? '0 : pos_q.bit_idx + 1'b1;
      if (slot_end) pos_d.slot = frame_end ? '0 : pos_q.slot + 1'b1;
      if (frame_end) pos_d.odd = ~pos_q.odd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_q_o = pos_q;
  assign pos_d_o = pos_d;

  // R4
  fsync_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q == '0));

  // R3
  parity_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && frame_end) |=> (pos_q.odd != $past(pos_q.odd)));

  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_i && !slot_end) |=> (pos_q.slot == $past(pos_q.slot)));
endmodule

// File: rtl/e1_block_gen.sv
module e1_block_gen
  import e1_slot_pkg::*;
#(
  parameter int unsigned SLOTS = SLOTS_PER_FRAME,
  parameter int unsigned FORCE_SLOT = G802_SLOT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  e1_pos_t          pos_d_i,
  input  logic [SLOTS-1:0] mask_i,
  input  logic             g802_en_i,
  output logic             blk_o
);
  logic force_hit, blk_d;

  assign force_hit = g802_en_i && (pos_d_i.slot == SLOT_W'(FORCE_SLOT))
                     && (pos_d_i.bit_idx == '0);
  assign blk_d = mask_i[pos_d_i.slot] | force_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blk_o <= 1'b0;
    else         blk_o <= blk_d;
  end
endmodule

// File: rtl/e1_link_clk_gen.sv
module e1_link_clk_gen
  import e1_slot_pkg::*;
#(
  parameter int unsigned FIRST = SA_FIRST,
  parameter int unsigned COUNT = SA_COUNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  e1_pos_t          pos_d_i,
  input  logic [COUNT-1:0] sel_i,
  output logic             link_o
);
  logic [COUNT-1:0] hit;
  logic             in_ts0;

  assign in_ts0 = pos_d_i.odd && (pos_d_i.slot == '0);

  for (genvar k = 0; k < COUNT; k++) begin : g_sa
    assign hit[k] = sel_i[k] && (pos_d_i.bit_idx == BIT_W'(FIRST + k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_o <= 1'b0;
    else         link_o <= in_ts0 && (|hit);
  end
endmodule

// File: rtl/e1_slot_timer.sv
module e1_slot_timer
  import e1_slot_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fsync_i,
  input  logic [SLOTS_PER_FRAME-1:0] blk_mask_i,
  input  logic                       g802_en_i,
  input  logic [SA_COUNT-1:0]        sa_sel_i,
  output logic                       chan_clk_o,
  output logic                       chan_blk_o,
  output logic                       link_clk_o,
  output logic [SLOT_W-1:0]          slot_o,
  output logic [BIT_W-1:0]           bit_o,
  output logic                       frame_odd_o
);
  e1_pos_t pos_q, pos_d;

  e1_pos_counter u_cnt (
    .clk_i, .rst_ni, .fsync_i,
    .pos_q_o(pos_q), .pos_d_o(pos_d)
  );

  e1_block_gen u_blk (
    .clk_i, .rst_ni, .pos_d_i(pos_d),
    .mask_i(blk_mask_i), .g802_en_i, .blk_o(chan_blk_o)
  );

  e1_link_clk_gen u_link (
    .clk_i, .rst_ni, .pos_d_i(pos_d),
    .sel_i(sa_sel_i), .link_o(link_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_clk_o <= 1'b0;
    else         chan_clk_o <= (pos_d.bit_idx == BIT_W'(BITS_PER_SLOT - 1));
  end

  assign slot_o      = pos_q.slot;
  assign bit_o       = pos_q.bit_idx;
  assign frame_odd_o = pos_q.odd;

  // R5
  chan_clk_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (chan_clk_o == (bit_o == BIT_W'(BITS_PER_SLOT - 1))));

  // R8
  link_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_clk_o |-> (frame_odd_o && slot_o == '0 && bit_o >= BIT_W'(SA_FIRST)));

  // R7
  g802_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (($past(g802_en_i) && slot_o == SLOT_W'(G802_SLOT) && bit_o == '0)
         |-> chan_blk_o));
endmodule

// File: tb/sim_e1_slot_timer.sv
module sim_e1_slot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [31:0] mask = '0;
  logic        g802 = 1'b0;
  logic [4:0]  sa_sel = '0;
  logic        chan_clk, chan_blk, link_clk, frame_odd;
  logic [4:0]  slot;
  logic [2:0]  bitn;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_bit = 0, m_slot = 0, m_odd = 0;
  bit e_clk = 0, e_blk = 0, e_link = 0;

  always #2.5 clk = ~clk;

  e1_slot_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .blk_mask_i(mask),
    .g802_en_i(g802), .sa_sel_i(sa_sel), .chan_clk_o(chan_clk),
    .chan_blk_o(chan_blk), .link_clk_o(link_clk), .slot_o(slot),
    .bit_o(bitn), .frame_odd_o(frame_odd)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s slot=%0d bit=%0d actual=%0d expected=%0d", req, m_slot, m_bit, act, exp);
    end
  endtask

  task automatic model_edge();
    if (fsync) begin
      m_bit = 0; m_slot = 0; m_odd = 0;
    end else if (m_bit == 7) begin
      m_bit = 0;
      if (m_slot == 31) begin m_slot = 0; m_odd = 1 - m_odd; end
      else m_slot++;
    end else m_bit++;
    e_clk = (m_bit == 7);
    e_blk = mask[m_slot] || (g802 && m_slot == 26 && m_bit == 0);
    e_link = (m_odd == 1) && (m_slot == 0) && (m_bit >= 3) && sa_sel[m_bit-3];
  endtask

  task automatic compare_all();
    chk("R2", {slot, bitn}, {m_slot[4:0], m_bit[2:0]});
    chk("R3", frame_odd, m_odd);
    chk("R5", chan_clk, e_clk);
    if (m_slot == 26 && m_bit == 0 && e_blk && !mask[26]) chk("R7", chan_blk, e_blk);
    else chk("R6", chan_blk, e_blk);
    if (e_link) chk("R8", link_clk, 1);
    else chk("R9", link_clk, 0);
  endtask

  // one clock: model advances with inputs seen at the edge, compare away from it
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
      fsync = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    mask = 32'hA5C3_0F81;
    #12;
    // R1: reset state before any edge
    chk("R1", {chan_clk, chan_blk, link_clk, frame_odd}, 0);
    chk("R1", {slot, bitn}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(600);

    // R8: all Sa positions selected across several frames
    sa_sel = 5'b11111;
    step(800);
    // R9: sparse selection, Sa5 and Sa8
    sa_sel = 5'b10010;
    step(600);

    // R4: sync mid-frame
    step(37);
    fsync = 1'b1;
    step(1);
    chk("R4", {slot, bitn, frame_odd}, 0);
    step(300);
    // R4: sync on the last slot of a non-alignment frame
    while (!(m_slot == 31 && m_odd == 1)) step(1);
    fsync = 1'b1;
    step(1);
    chk("R4", {slot, bitn, frame_odd}, 0);

    // R7: mask bit 26 clear, force enabled, then disabled
    mask = 32'h0000_0000;
    g802 = 1'b1;
    step(600);
    g802 = 1'b0;
    step(300);
    mask = 32'hFFFF_FFFF;
    g802 = 1'b1;
    step(300);

    // R6: walking patterns
    for (int p = 0; p < 6; p++) begin
      mask = 32'h1 << (p * 5);
      sa_sel = 5'(p * 7);
      step(260);
    end

    // R10: a single-slot mask gives exactly eight consecutive block cycles
    mask = 32'h0000_0008;
    g802 = 1'b0;
    while (!(m_slot == 0 && m_bit == 0)) step(1);
    begin
      int run = 0;
      for (int i = 0; i < 256; i++) begin
        step(1);
        if (chan_blk) run++;
      end
      chk("R10", run, 8);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule